// File: doc/BRIEF.md
# Two's-Complement Floating-Point Standardiser

This unit takes a raw floating-point result from an arithmetic datapath and returns it in standard form. The word packs a sign bit at the top, an exponent biased by half its range below it, and a mantissa in the low bits. The sign bit and the mantissa together make one two's complement fraction. Extra guard bits from the datapath extend that fraction below the mantissa. The unit shifts the fraction left until its top two bits differ, and lowers the exponent by the shift distance. It then either rounds on the first discarded bit or truncates, applies the fixed correction a rounding carry needs, and classifies the exponent as in range, below zero or above the largest code.

Each result passes through one internal classification with four outcomes, and one `unique case` selects among them. NORMAL packs the standardised fraction with its exponent. ZERO covers an all-zero input fraction. UNDER covers an exponent that ends below zero. OVER covers an exponent that ends above the largest code. Each accepted input moves the output register to the outcome of that input one clock later. A cycle with no input leaves the register holding its last result.

Top module: `fpn_normalise`

## Requirements
- R1: A result appears with `out_valid` high exactly one clock after `in_valid` is sampled high. A clock with `in_valid` low drives `out_valid` low and leaves `out_word` and `out_overflow` unchanged.
- R2: The input and output words use the same field layout. The sign is bit W-1, the exponent is the next EXP_W bits, and the mantissa is the low MANT_W bits. The fraction is {sign, mantissa, in_guard}, read as a two's complement number with in_guard as its least significant bits.
- R3: A nonzero result is standardised: its sign bit differs from the top mantissa bit (bit MANT_W-1). To reach this, the unit shifts the fraction left and subtracts the shift distance from the exponent.
- R4: With `in_single`=1, the unit adds 1 at the mantissa LSB when the first bit below it after normalisation (the top guard bit) is 1.
- R5: With `in_single`=0, the unit never rounds, and it discards the guard bits after normalisation.
- R6: If rounding carries a positive fraction out of range, the mantissa becomes binary 0.1000…, which is 1 followed by zeros, and the exponent rises by one.
- R7: If rounding turns a negative fraction into exactly -1/2, the unit renormalises it to -1 (sign 1, mantissa all zero), and the exponent drops by one.
- R8: An all-zero input fraction gives an all-zero output word with `out_overflow` low.
- R9: If the final exponent is below zero, the output word is all zeros and `out_overflow` is low.
- R10: If the final exponent is above 2^EXP_W-1, `out_overflow` goes high, the exponent field reads all ones, and the output keeps the standardised fraction.
- R11: During reset, `out_valid`, `out_word` and `out_overflow` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks a raw result to standardise |
| in_word | input | 1+EXP_W+MANT_W | Raw result: sign, biased exponent, mantissa |
| in_guard | input | GUARD_W | Fraction bits below the mantissa |
| in_single | input | 1 | 1 rounds on the first dropped bit, 0 truncates |
| out_valid | output | 1 | Result register holds a new result |
| out_word | output | 1+EXP_W+MANT_W | Standardised result |
| out_overflow | output | 1 | Exponent exceeded its largest code |

## Verification
The bench builds the unit with a 4-bit exponent, a 5-bit mantissa and 2 guard bits. This makes the input space 4096 words per rounding mode, so the sweep covers every input in both modes. At this size the sweep reaches every shift distance and every exponent underflow from a deep shift. It also reaches the positive and negative rounding corrections, both at the largest exponent, where a carry overflows, and at exponent zero, where the -1/2 fix-up underflows. An idle cycle after every sixteenth vector checks that the result register holds.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

    // Outcome of one standardisation, chosen before the result is packed.
    typedef enum logic [1:0] {
        CLS_NORMAL = 2'd0,
        CLS_ZERO   = 2'd1,
        CLS_UNDER  = 2'd2,
        CLS_OVER   = 2'd3
    } fpn_class_e;

endpackage

// File: rtl/fpn_lead_count.sv
// Counts the copies of the sign bit that follow it: the left shift that
// makes the top two bits of a two's complement fraction differ.
module fpn_lead_count #(
    parameter int F   = 48,
    parameter int SHW = 6
) (
    input  logic [F-1:0]   frac,
    output logic [SHW-1:0] shamt,
    output logic           is_zero
);

    logic run;

    always_comb begin
        shamt = '0;
        run   = 1'b1;
        for (int i = F - 2; i >= 0; i--) begin
            if (run && (frac[i] == frac[F-1])) begin
                shamt = shamt + SHW'(1);
            end else begin
                run = 1'b0;
            end
        end
    end

    assign is_zero = ~|frac;

endmodule

// File: rtl/fpn_shift_left.sv
// Logarithmic left shifter, one stage per bit of the shift amount.
module fpn_shift_left #(
    parameter int F   = 48,
    parameter int SHW = 6
) (
    input  logic [F-1:0]   din,
    input  logic [SHW-1:0] amt,
    output logic [F-1:0]   dout
);

    logic [F-1:0] stage [SHW+1];

    assign stage[0] = din;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        assign stage[k+1] = amt[k] ? (stage[k] << (2 ** k)) : stage[k];
    end

    assign dout = stage[SHW];

endmodule

// File: rtl/fpn_round.sv
// Rounds a standardised fraction on its first dropped bit and repairs the
// two results that rounding can push out of standard form.
module fpn_round #(
    parameter int K  = 40,
    parameter int EW = 10
) (
    input  logic [K-1:0]         kept,
    input  logic                 first_drop,
    input  logic                 single,
    input  logic signed [EW-1:0] exp_in,
    output logic [K-1:0]         frac_out,
    output logic signed [EW-1:0] exp_out
);

    logic [K-1:0] sum;
    logic         pos_wrap;
    logic         neg_half;

    assign sum      = kept + K'(single & first_drop);
    assign pos_wrap = ~kept[K-1] & sum[K-1];
    assign neg_half = (sum[K-1:K-2] == 2'b11) && (sum[K-3:0] == '0);

    always_comb begin
        frac_out = sum;
        exp_out  = exp_in;
        if (pos_wrap) begin
            frac_out = {2'b01, {(K-2){1'b0}}};
            exp_out  = exp_in + EW'(1);
        end else if (neg_half) begin
            frac_out = {2'b10, {(K-2){1'b0}}};
            exp_out  = exp_in - EW'(1);
        end
    end

endmodule

// File: rtl/fpn_normalise.sv
module fpn_normalise
    import fpn_pkg::*;
#(
    parameter int EXP_W   = 8,
    parameter int MANT_W  = 39,
    parameter int GUARD_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [EXP_W+MANT_W:0]     in_word,
    input  logic [GUARD_W-1:0]        in_guard,
    input  logic                      in_single,
    output logic                      out_valid,
    output logic [EXP_W+MANT_W:0]     out_word,
    output logic                      out_overflow
);

    localparam int W   = 1 + EXP_W + MANT_W;
    localparam int F   = 1 + MANT_W + GUARD_W;
    localparam int K   = 1 + MANT_W;
    localparam int SHW = $clog2(F);
    localparam int EW  = ((EXP_W > SHW) ? EXP_W : SHW) + 2;

    localparam logic signed [EW-1:0] EXP_TOP = {{(EW-EXP_W){1'b0}}, {EXP_W{1'b1}}};

    logic [F-1:0]         frac;
    logic [EXP_W-1:0]     exp_raw;
    logic [SHW-1:0]       shamt;
    logic                 lc_zero;
    logic [F-1:0]         norm;
    logic signed [EW-1:0] e_norm;
    logic [K-1:0]         frac_fin;
    logic signed [EW-1:0] e_fin;
    logic                 unused_tail;
    fpn_class_e           cls;
    logic [W-1:0]         word_nxt;
    logic                 ovf_nxt;

    assign frac    = {in_word[W-1], in_word[MANT_W-1:0], in_guard};
    assign exp_raw = in_word[W-2 -: EXP_W];

    fpn_lead_count #(.F(F), .SHW(SHW)) u_count (
        .frac    (frac),
        .shamt   (shamt),
        .is_zero (lc_zero)
    );

    fpn_shift_left #(.F(F), .SHW(SHW)) u_shift (
        .din  (frac),
        .amt  (shamt),
        .dout (norm)
    );

    assign e_norm = $signed({{(EW-EXP_W){1'b0}}, exp_raw})
                  - $signed({{(EW-SHW){1'b0}}, shamt});

    fpn_round #(.K(K), .EW(EW)) u_round (
        .kept       (norm[F-1:GUARD_W]),
        .first_drop (norm[GUARD_W-1]),
        .single     (in_single),
        .exp_in     (e_norm),
        .frac_out   (frac_fin),
        .exp_out    (e_fin)
    );

    // Guard bits below the first dropped one have no effect on the result.
    assign unused_tail = ^norm;

    always_comb begin
        if (lc_zero) begin
            cls = CLS_ZERO;
        end else if (e_fin[EW-1]) begin
            cls = CLS_UNDER;
        end else if (e_fin > EXP_TOP) begin
            cls = CLS_OVER;
        end else begin
            cls = CLS_NORMAL;
        end
    end

    always_comb begin
        unique case (cls)
            CLS_ZERO, CLS_UNDER: begin
                word_nxt = '0;
                ovf_nxt  = 1'b0;
            end
            CLS_OVER: begin
                word_nxt = {frac_fin[K-1], {EXP_W{1'b1}}, frac_fin[K-2:0]};
                ovf_nxt  = 1'b1;
            end
            CLS_NORMAL: begin
                word_nxt = {frac_fin[K-1], e_fin[EXP_W-1:0], frac_fin[K-2:0]};
                ovf_nxt  = 1'b0;
            end
            default: begin
                word_nxt = '0;
                ovf_nxt  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_word     <= '0;
            out_overflow <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_word     <= word_nxt;
                out_overflow <= ovf_nxt;
            end
        end
    end

    // R1: one clock of latency, and the result holds through idle clocks.
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_word) && $stable(out_overflow)));

    // R3: the counter and the shifter together yield a standardised fraction.
    assert_norm_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lc_zero) |-> (norm[F-1] != norm[F-2]));

    // R3: every nonzero registered result is in standard form.
    assert_standard_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (|out_word)) |-> (out_word[W-1] != out_word[MANT_W-1]));

    // R8: a zero fraction gives a zero word and no overflow.
    assert_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lc_zero) |=> ((out_word == '0) && !out_overflow));

    // R10: overflow always shows an all-ones exponent field.
    assert_overflow_field_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_overflow |-> (out_word[W-2 -: EXP_W] == {EXP_W{1'b1}}));

endmodule

// File: tb/test_fpn_normalise.sv
module test_fpn_normalise;

    localparam int EXP_W   = 4;
    localparam int MANT_W  = 5;
    localparam int GUARD_W = 2;
    localparam int W       = 1 + EXP_W + MANT_W;
    localparam int F       = 1 + MANT_W + GUARD_W;
    localparam int K       = 1 + MANT_W;
    localparam int EMAX    = (1 << EXP_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [W-1:0]     in_word;
    logic [GUARD_W-1:0] in_guard;
    logic             in_single;
    logic             out_valid;
    logic [W-1:0]     out_word;
    logic             out_overflow;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fpn_normalise #(.EXP_W(EXP_W), .MANT_W(MANT_W), .GUARD_W(GUARD_W)) i_fpn_normalise (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_word      (in_word),
        .in_guard     (in_guard),
        .in_single    (in_single),
        .out_valid    (out_valid),
        .out_word     (out_word),
        .out_overflow (out_overflow)
    );

    task automatic check(input bit ok, input string tag, input logic [W+1:0] act,
                         input logic [W+1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual {valid,ovf,word}=%h expected %h", tag, act, exp);
        end
    endtask

    // Arithmetic model: returns {overflow, word}; tag names the rule that applied.
    function automatic logic [W:0] model(input logic [W-1:0] w, input logic [GUARD_W-1:0] g,
                                         input logic single, output string tag);
        logic [F-1:0] fr;
        logic [K-1:0] kb;
        int v, e, kept, rb, half, kh;
        bit ovf;
        fr   = {w[W-1], w[MANT_W-1:0], g};        // R2: sign, mantissa, guard
        v    = int'($signed(fr));
        e    = int'(w[W-2 -: EXP_W]);
        half = 1 << (F - 2);
        kh   = 1 << (K - 2);
        if (v == 0) begin
            tag = "R8";
            return '0;
        end
        while (v >= -half && v < half) begin       // R3: shift until top bits differ
            v = v * 2;
            e = e - 1;
        end
        kept = v >>> GUARD_W;
        rb   = (v >> (GUARD_W - 1)) & 1;
        tag  = single ? "R2/R3/R4" : "R2/R3/R5";
        if (single && rb == 1) kept = kept + 1;
        if (kept == 2 * kh) begin                  // R6
            kept = kh;
            e    = e + 1;
            tag  = "R6";
        end else if (kept == -kh) begin            // R7
            kept = -2 * kh;
            e    = e - 1;
            tag  = "R7";
        end
        if (e < 0) begin
            tag = "R9";
            return '0;
        end
        ovf = 1'b0;
        if (e > EMAX) begin                        // R10
            ovf = 1'b1;
            e   = EMAX;
            tag = "R10";
        end
        kb = kept[K-1:0];
        return {ovf, kb[K-1], e[EXP_W-1:0], kb[K-2:0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W:0] exp_r;
        logic [W:0] last_r;
        string      tag;
        int         n;
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_word   = '0;
        in_guard  = '0;
        in_single = 1'b0;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!out_valid && out_word == '0 && !out_overflow, "R11",
              {out_valid, out_overflow, out_word}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && out_word == '0 && !out_overflow, "R11/R1",
              {out_valid, out_overflow, out_word}, '0);

        n = 0;
        last_r = '0;
        for (int s = 0; s < 2; s++) begin
            for (int idx = 0; idx < (1 << (W + GUARD_W)); idx++) begin
                in_valid  = 1'b1;
                in_single = s[0];
                in_word   = idx[W+GUARD_W-1:GUARD_W];
                in_guard  = idx[GUARD_W-1:0];
                exp_r     = model(in_word, in_guard, in_single, tag);
                @(negedge clk);
                check(out_valid && {out_overflow, out_word} == exp_r, tag,
                      {out_valid, out_overflow, out_word}, {1'b1, exp_r});
                last_r = exp_r;
                n++;
                if (n % 16 == 0) begin
                    // R1: idle cycle with scrambled inputs must not disturb the result
                    in_valid = 1'b0;
                    in_word  = ~in_word;
                    in_guard = ~in_guard;
                    @(negedge clk);
                    check(!out_valid && {out_overflow, out_word} == last_r, "R1",
                          {out_valid, out_overflow, out_word}, {1'b0, last_r});
                end
            end
        end
        in_valid = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule